// File: doc/BRIEF.md
# Programmable Phase External Bus Controller

This block runs one external memory or peripheral access at a time as a fixed sequence of phases: address setup, command delay, data setup or bus turnaround, access, and hold. A host places a request with address, write data, direction, byte enables, a chip-select index and a bus-format select. The controller then drives the address latch strobe, read and write strobes, a one-hot chip select, the address lines and a shared address/data output with its output enable. On the last access cycle it samples read data and returns it with a one-cycle done pulse.

Each chip select has its own phase lengths, given on configuration inputs and captured when a request is accepted. Address setup is lengthened only when the access leaves the address window of the previous access. The access phase can be stretched by a ready handshake, sampled either directly or through one extra synchronising register. Every bus output comes straight from a flop.

Top module: `ebc_bus_ctrl`

## Requirements
- R1: After acceptance the chip select stays active for AB+C+D+E(+ready waits)+F cycles. AB is cfg_ab_base+1 (plus the window extension), C is cfg_cmd, D is cfg_dset, E is cfg_acc+1 and F is cfg_hold. The phases always come in that order, and the first read or write strobe cycle falls AB+C cycles after the first chip-select cycle.
- R2: A phase programmed to zero length (command delay, data setup or hold) takes no cycle. The next non-empty phase follows directly.
- R3: Address setup is lengthened by cfg_ab_ext cycles only when req_addr[AW-1:WIN_LSB] differs from that of the previous accepted request. The first request after reset counts as a change.
- R4: With req_mux=1 the shared bus carries req_addr[DW-1:0] with the enable high during address setup. For a write it then carries the write data with the enable high until the end of the hold phase. For a read it is released (enable low) after address setup.
- R5: With req_mux=0 the shared bus never carries the address. A write drives the data with the enable high from command delay to the end of the hold phase, and a read never enables it. bus_addr and bus_be hold the request values for the whole cycle.
- R6: bus_ale is high only during address setup. bus_rd or bus_wr (never both) is high from the end of command delay through the access phase and its ready waits. bus_cs is the one-hot code of req_cs while the cycle runs.
- R7: With ready enabled and synchronous, the ready pin is sampled in the last programmed access cycle. If it is inactive, wait cycles follow until a cycle in which it is sampled active.
- R8: With ready enabled and asynchronous, at least one wait cycle is always inserted. The decision in each wait cycle uses the pin value from the cycle before.
- R9: cfg_rdy_pol gives the active level of the ready pin (1 = high active, 0 = low active).
- R10: With cfg_rdy_en=0 the ready pin has no effect on cycle length.
- R11: Read data is taken from bus_din on the clock edge that ends the strobe. It appears on rdata with a one-cycle done pulse in the cycle after the last chip-select cycle.
- R12: busy is high from acceptance until done. A request raised while busy is ignored: it starts no cycle and changes no output.
- R13: After reset every bus output, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_cs | input | CSW | Chip-select index |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | BEW | Byte enables |
| req_mux | input | 1 | 1 = shared address/data bus, 0 = separate address lines |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Captured read data |
| cfg_ab_base | input | NCS | Per chip select: address setup base (0 = 1 cycle, 1 = 2 cycles) |
| cfg_ab_ext | input | 2*NCS | Per chip select: extra setup cycles on a window change |
| cfg_cmd | input | 2*NCS | Per chip select: command delay cycles |
| cfg_dset | input | NCS | Per chip select: data setup cycles |
| cfg_acc | input | E_W*NCS | Per chip select: access cycles minus one |
| cfg_hold | input | 2*NCS | Per chip select: hold cycles |
| cfg_rdy_en | input | NCS | Per chip select: ready handshake on |
| cfg_rdy_async | input | NCS | Per chip select: ready through synchroniser |
| cfg_rdy_pol | input | NCS | Per chip select: ready active level |
| bus_ale | output | 1 | Address latch strobe |
| bus_cs | output | NCS | One-hot chip select |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | AW | Address lines |
| bus_be | output | BEW | Byte enables |
| bus_ad_out | output | DW | Shared address/data output value |
| bus_ad_oe | output | 1 | Shared bus output enable |
| bus_din | input | DW | Read data from the bus |
| bus_ready | input | 1 | Ready handshake pin |

## Verification
Two functions can fall on the same clock edge: the ready decision that ends the access phase, and the capture of read data together with the fall of the read strobe. The bench changes bus_din every cycle to a value that encodes the cycle number. It raises ready before, at and after the last programmed access cycle, in both synchronous and asynchronous mode and at both polarities. A result counts as correct only if the returned word is the one present in the last strobe cycle and the strobe length matches the wait count worked out from the requirements.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_AB, PH_C, PH_D, PH_E, PH_WAIT, PH_F, PH_DONE
  } ebc_phase_e;
endpackage

// File: rtl/ebc_ready_sync.sv
module ebc_ready_sync (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic pol,
  output logic act_now,
  output logic act_sync
);
  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin;
  end

  assign act_now  = (pin == pol);
  assign act_sync = (pin_q == pol);
endmodule

// File: rtl/ebc_window_track.sv
module ebc_window_track #(
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [WW-1:0] win,
  output logic          changed
);
  logic [WW-1:0] last_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '0;
      seen_q <= 1'b0;
    end else if (accept) begin
      last_q <= win;
      seen_q <= 1'b1;
    end
  end

  assign changed = !seen_q || (win != last_q);
endmodule

// File: rtl/ebc_phase_seq.sv
module ebc_phase_seq
  import ebc_pkg::*;
#(
  parameter int NCS = 4,
  parameter int CSW = 2,
  parameter int E_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [CSW-1:0]   req_cs,
  input  logic             win_changed,
  input  logic [NCS-1:0]   cfg_ab_base,
  input  logic [2*NCS-1:0] cfg_ab_ext,
  input  logic [2*NCS-1:0] cfg_cmd,
  input  logic [NCS-1:0]   cfg_dset,
  input  logic [E_W*NCS-1:0] cfg_acc,
  input  logic [2*NCS-1:0] cfg_hold,
  input  logic [NCS-1:0]   cfg_rdy_en,
  input  logic [NCS-1:0]   cfg_rdy_async,
  input  logic [NCS-1:0]   cfg_rdy_pol,
  input  logic             rdy_now,
  input  logic             rdy_sync,
  output logic             rdy_pol,
  output logic             accept,
  output logic             acc_end,
  output ebc_phase_e       phase_q,
  output ebc_phase_e       phase_nxt
);
  localparam int CNT_W = (E_W > 3) ? E_W : 3;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [1:0]       c_len, f_len;
  logic             d_len, ren_q, rasync_q;
  logic [E_W-1:0]   e_m1;
  logic [2:0]       ab_in;
  logic             finish;

  assign accept = (phase_q == PH_IDLE) && req_valid;

  always_comb begin
    ab_in = 3'(cfg_ab_base[req_cs]) + 3'd1
          + (win_changed ? 3'(cfg_ab_ext[req_cs*2 +: 2]) : 3'd0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_len <= '0; d_len <= 1'b0; e_m1 <= '0; f_len <= '0;
      ren_q <= 1'b0; rasync_q <= 1'b0; rdy_pol <= 1'b1;
    end else if (accept) begin
      c_len    <= cfg_cmd[req_cs*2 +: 2];
      d_len    <= cfg_dset[req_cs];
      e_m1     <= cfg_acc[req_cs*E_W +: E_W];
      f_len    <= cfg_hold[req_cs*2 +: 2];
      ren_q    <= cfg_rdy_en[req_cs];
      rasync_q <= cfg_rdy_async[req_cs];
      rdy_pol  <= cfg_rdy_pol[req_cs];
    end
  end

  always_comb begin
    phase_nxt = phase_q;
    cnt_n     = cnt_q;
    finish    = 1'b0;
    case (phase_q)
      PH_IDLE: if (req_valid) begin
        phase_nxt = PH_AB;
        cnt_n     = CNT_W'(ab_in) - ONE;
      end
      PH_AB: begin
        if (cnt_q != '0) cnt_n = cnt_q - ONE;
        else if (c_len != 2'd0) begin phase_nxt = PH_C; cnt_n = CNT_W'(c_len) - ONE; end
        else if (d_len) begin phase_nxt = PH_D; cnt_n = '0; end
        else begin phase_nxt = PH_E; cnt_n = CNT_W'(e_m1); end
      end
      PH_C: begin
        if (cnt_q != '0) cnt_n = cnt_q - ONE;
        else if (d_len) begin phase_nxt = PH_D; cnt_n = '0; end
        else begin phase_nxt = PH_E; cnt_n = CNT_W'(e_m1); end
      end
      PH_D: begin
        phase_nxt = PH_E;
        cnt_n     = CNT_W'(e_m1);
      end
      PH_E: begin
        if (cnt_q != '0) cnt_n = cnt_q - ONE;
        else if (!ren_q) finish = 1'b1;
        else if (rasync_q) phase_nxt = PH_WAIT;
        else if (rdy_now) finish = 1'b1;
        else phase_nxt = PH_WAIT;
      end
      PH_WAIT: if (rasync_q ? rdy_sync : rdy_now) finish = 1'b1;
      PH_F: begin
        if (cnt_q != '0) cnt_n = cnt_q - ONE;
        else phase_nxt = PH_DONE;
      end
      PH_DONE: phase_nxt = PH_IDLE;
      default: phase_nxt = PH_IDLE;
    endcase
    if (finish) begin
      if (f_len != 2'd0) begin phase_nxt = PH_F; cnt_n = CNT_W'(f_len) - ONE; end
      else phase_nxt = PH_DONE;
    end
  end

  assign acc_end = finish;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_nxt;
      cnt_q   <= cnt_n;
    end
  end

  assert_done_to_idle_R11: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_DONE |=> phase_q == PH_IDLE);
  assert_wait_needs_ready_R10: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_WAIT |-> ren_q);
  assert_async_min_wait_R8: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_E && cnt_q == '0 && ren_q && rasync_q) |=> phase_q == PH_WAIT);
  assert_no_restart_busy_R12: assert property (@(posedge clk) disable iff (rst)
    (phase_q inside {PH_C, PH_D, PH_E, PH_WAIT, PH_F, PH_DONE}) |=> phase_q != PH_AB);
endmodule

// File: rtl/ebc_bus_ctrl.sv
module ebc_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int NCS     = 4,
  parameter int CSW     = $clog2(NCS),
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int BEW     = DW / 8,
  parameter int WIN_LSB = 16,
  parameter int E_W     = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [CSW-1:0]     req_cs,
  input  logic [AW-1:0]      req_addr,
  input  logic [DW-1:0]      req_wdata,
  input  logic               req_write,
  input  logic [BEW-1:0]     req_be,
  input  logic               req_mux,
  output logic               busy,
  output logic               done,
  output logic [DW-1:0]      rdata,
  input  logic [NCS-1:0]     cfg_ab_base,
  input  logic [2*NCS-1:0]   cfg_ab_ext,
  input  logic [2*NCS-1:0]   cfg_cmd,
  input  logic [NCS-1:0]     cfg_dset,
  input  logic [E_W*NCS-1:0] cfg_acc,
  input  logic [2*NCS-1:0]   cfg_hold,
  input  logic [NCS-1:0]     cfg_rdy_en,
  input  logic [NCS-1:0]     cfg_rdy_async,
  input  logic [NCS-1:0]     cfg_rdy_pol,
  output logic               bus_ale,
  output logic [NCS-1:0]     bus_cs,
  output logic               bus_rd,
  output logic               bus_wr,
  output logic [AW-1:0]      bus_addr,
  output logic [BEW-1:0]     bus_be,
  output logic [DW-1:0]      bus_ad_out,
  output logic               bus_ad_oe,
  input  logic [DW-1:0]      bus_din,
  input  logic               bus_ready
);
  localparam int WW = AW - WIN_LSB;

  ebc_phase_e     phase_q, phase_nxt;
  logic           accept, acc_end, win_changed;
  logic           rdy_now, rdy_sync, rdy_pol;
  logic           lat_write, lat_mux;
  logic [CSW-1:0] lat_cs;
  logic [DW-1:0]  lat_alo, lat_wdata;

  ebc_window_track #(.WW(WW)) u_win (
    .clk(clk), .rst(rst), .accept(accept),
    .win(req_addr[AW-1:WIN_LSB]), .changed(win_changed)
  );

  ebc_ready_sync u_rdy (
    .clk(clk), .rst(rst), .pin(bus_ready), .pol(rdy_pol),
    .act_now(rdy_now), .act_sync(rdy_sync)
  );

  ebc_phase_seq #(.NCS(NCS), .CSW(CSW), .E_W(E_W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cs(req_cs),
    .win_changed(win_changed),
    .cfg_ab_base(cfg_ab_base), .cfg_ab_ext(cfg_ab_ext), .cfg_cmd(cfg_cmd),
    .cfg_dset(cfg_dset), .cfg_acc(cfg_acc), .cfg_hold(cfg_hold),
    .cfg_rdy_en(cfg_rdy_en), .cfg_rdy_async(cfg_rdy_async), .cfg_rdy_pol(cfg_rdy_pol),
    .rdy_now(rdy_now), .rdy_sync(rdy_sync), .rdy_pol(rdy_pol),
    .accept(accept), .acc_end(acc_end), .phase_q(phase_q), .phase_nxt(phase_nxt)
  );

  // Values of the running request, taken from the inputs on the accept edge.
  logic           cur_write, cur_mux, in_cyc, cmd_ph, drive_ph, addr_ph;
  logic [CSW-1:0] cur_cs;
  logic [DW-1:0]  cur_alo, cur_wdata;
  logic [NCS-1:0] cs_vec;

  always_comb begin
    cur_write = accept ? req_write : lat_write;
    cur_mux   = accept ? req_mux   : lat_mux;
    cur_cs    = accept ? req_cs    : lat_cs;
    cur_alo   = accept ? req_addr[DW-1:0] : lat_alo;
    cur_wdata = accept ? req_wdata : lat_wdata;
    in_cyc    = phase_nxt inside {PH_AB, PH_C, PH_D, PH_E, PH_WAIT, PH_F};
    cmd_ph    = phase_nxt inside {PH_D, PH_E, PH_WAIT};
    drive_ph  = phase_nxt inside {PH_C, PH_D, PH_E, PH_WAIT, PH_F};
    addr_ph   = cur_mux && (phase_nxt == PH_AB);
    cs_vec    = '0;
    if (in_cyc) cs_vec[cur_cs] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_write <= 1'b0; lat_mux <= 1'b0; lat_cs <= '0;
      lat_alo <= '0; lat_wdata <= '0;
      bus_addr <= '0; bus_be <= '0;
      bus_ale <= 1'b0; bus_cs <= '0; bus_rd <= 1'b0; bus_wr <= 1'b0;
      bus_ad_out <= '0; bus_ad_oe <= 1'b0;
      done <= 1'b0; rdata <= '0;
    end else begin
      if (accept) begin
        lat_write <= req_write; lat_mux <= req_mux; lat_cs <= req_cs;
        lat_alo   <= req_addr[DW-1:0]; lat_wdata <= req_wdata;
        bus_addr  <= req_addr; bus_be <= req_be;
      end
      bus_ale    <= (phase_nxt == PH_AB);
      bus_cs     <= cs_vec;
      bus_rd     <= cmd_ph && !cur_write;
      bus_wr     <= cmd_ph && cur_write;
      bus_ad_oe  <= addr_ph || (cur_write && drive_ph);
      bus_ad_out <= addr_ph ? cur_alo : cur_wdata;
      done       <= (phase_nxt == PH_DONE);
      if (acc_end && !lat_write) rdata <= bus_din;
    end
  end

  assign busy = (phase_q != PH_IDLE);

  assert_cmd_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));
  assert_cs_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_cs));
  assert_ale_setup_only_R6: assert property (@(posedge clk) disable iff (rst)
    bus_ale |-> (!bus_rd && !bus_wr && bus_cs != '0));
  assert_read_released_R4: assert property (@(posedge clk) disable iff (rst)
    bus_rd |-> !bus_ad_oe);
  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/ebc_bus_ctrl_bench.sv
module ebc_bus_ctrl_bench;
  localparam int NCS = 4, AW = 24, DW = 16, E_W = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_mux = 1'b0;
  logic [1:0] req_cs = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic busy, done, bus_ale, bus_rd, bus_wr, bus_ad_oe;
  logic [DW-1:0] rdata, bus_ad_out;
  logic [DW-1:0] bus_din = '0;
  logic bus_ready = 1'b0;
  logic [NCS-1:0] bus_cs;
  logic [AW-1:0] bus_addr;
  logic [1:0] bus_be;
  logic [NCS-1:0] cfg_ab_base = '0, cfg_dset = '0, cfg_rdy_en = '0, cfg_rdy_async = '0, cfg_rdy_pol = '1;
  logic [2*NCS-1:0] cfg_ab_ext = '0, cfg_cmd = '0, cfg_hold = '0;
  logic [E_W*NCS-1:0] cfg_acc = '0;

  ebc_bus_ctrl u_ebc_bus_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cs(req_cs), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_be(req_be), .req_mux(req_mux),
    .busy(busy), .done(done), .rdata(rdata),
    .cfg_ab_base(cfg_ab_base), .cfg_ab_ext(cfg_ab_ext), .cfg_cmd(cfg_cmd), .cfg_dset(cfg_dset),
    .cfg_acc(cfg_acc), .cfg_hold(cfg_hold), .cfg_rdy_en(cfg_rdy_en),
    .cfg_rdy_async(cfg_rdy_async), .cfg_rdy_pol(cfg_rdy_pol),
    .bus_ale(bus_ale), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
    .bus_din(bus_din), .bus_ready(bus_ready)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_base[NCS], m_ext[NCS], m_c[NCS], m_d[NCS], m_e[NCS], m_f[NCS];
  int m_ren[NCS], m_rasync[NCS], m_rpol[NCS];
  int rdy_at = 1000;
  bit win_seen = 0;
  logic [7:0] win_prev = '0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int cs, input int base, input int ext, input int c, input int d,
                         input int e, input int f, input int ren, input int rasync, input int rpol);
    m_base[cs] = base; m_ext[cs] = ext; m_c[cs] = c; m_d[cs] = d; m_e[cs] = e; m_f[cs] = f;
    m_ren[cs] = ren; m_rasync[cs] = rasync; m_rpol[cs] = rpol;
    cfg_ab_base[cs] = base[0]; cfg_ab_ext[cs*2 +: 2] = ext[1:0]; cfg_cmd[cs*2 +: 2] = c[1:0];
    cfg_dset[cs] = d[0]; cfg_acc[cs*E_W +: E_W] = 5'(e - 1); cfg_hold[cs*2 +: 2] = f[1:0];
    cfg_rdy_en[cs] = ren[0]; cfg_rdy_async[cs] = rasync[0]; cfg_rdy_pol[cs] = rpol[0];
  endtask

  // One bus cycle; tag names the requirement the cycle timing proves.
  task automatic run_txn(input int cs, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                         input logic wr, input logic mux, input string tag, input bit poke);
    int ab, lastE, w, cmd_lo, cmd_hi, total;
    int n_ale = 0, n_cmd = 0, n_cs = 0, first_cmd = -1, done_idx = -1;
    int e_ctl = 0, e_ad = 0, e_adr = 0, busy_mid = 0;
    bit chg = !win_seen || (addr[23:16] != win_prev);
    ab = m_base[cs] + 1 + (chg ? m_ext[cs] : 0);
    win_seen = 1; win_prev = addr[23:16];
    lastE = ab + m_c[cs] + m_d[cs] + m_e[cs] - 1;
    if (m_ren[cs] == 0) w = 0;
    else if (m_rasync[cs] == 0) w = (rdy_at > lastE) ? rdy_at - lastE : 0;
    else w = (rdy_at + 1 - lastE > 1) ? rdy_at + 1 - lastE : 1;
    cmd_lo = ab + m_c[cs];
    cmd_hi = cmd_lo + m_d[cs] + m_e[cs] + w;
    total  = cmd_hi + m_f[cs];
    bus_ready = (m_rpol[cs] != 0) ? 1'b0 : 1'b1;
    req_cs = 2'(cs); req_addr = addr; req_wdata = wd; req_write = wr; req_mux = mux;
    req_be = 2'(cs + 1); req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    for (int idx = 0; idx < 300; idx++) begin
      bit act = (idx >= rdy_at);
      bus_ready = act ? m_rpol[cs][0] : ~m_rpol[cs][0];
      bus_din = 16'hA000 + 16'(idx);
      if (done) begin done_idx = idx; break; end
      if (idx == 1) busy_mid = busy;
      if (poke && idx == 2) begin
        req_valid = 1'b1; req_addr = addr ^ 24'h5A5A5A; req_cs = 2'(cs + 1); req_write = ~wr;
      end
      if (poke && idx == 3) req_valid = 1'b0;
      if (bus_cs != 0) n_cs++;
      if (bus_ale) n_ale++;
      if (bus_rd || bus_wr) begin n_cmd++; if (first_cmd < 0) first_cmd = idx; end
      if (idx < total) begin
        bit ecmd = (idx >= cmd_lo) && (idx < cmd_hi);
        bit eoe = (mux && idx < ab) || (wr && idx >= ab);
        if (bus_cs != NCS'(1 << cs) || bus_ale != (idx < ab) || bus_rd != (ecmd && !wr) ||
            bus_wr != (ecmd && wr)) e_ctl++;
        if (bus_ad_oe != eoe) e_ad++;
        if (eoe && bus_ad_out != ((mux && idx < ab) ? addr[15:0] : wd)) e_ad++;
        if (bus_addr != addr || bus_be != 2'(cs + 1)) e_adr++;
      end
      @(negedge clk);
    end
    chk(n_ale == ab, tag, n_ale, ab);
    chk(first_cmd == cmd_lo, tag, first_cmd, cmd_lo);
    chk(n_cmd == cmd_hi - cmd_lo, tag, n_cmd, cmd_hi - cmd_lo);
    chk(n_cs == total, tag, n_cs, total);
    chk(done_idx == total, "R11 done timing", done_idx, total);
    chk(busy_mid == 1, "R12 busy", busy_mid, 1);
    chk(e_ctl == 0, "R6 strobes", e_ctl, 0);
    chk(e_ad == 0, mux ? "R4 shared bus" : "R5 shared bus", e_ad, 0);
    chk(e_adr == 0, "R5 address lines", e_adr, 0);
    if (!wr) chk(rdata == 16'hA000 + 16'(cmd_hi - 1), "R11 read capture", rdata, 16'hA000 + 16'(cmd_hi - 1));
    @(negedge clk);
    chk(done == 0, "R11 done pulse", done, 0);
    rdy_at = 1000;
  endtask

  task automatic t_reset;
    chk(!busy && !done && !bus_ale && bus_cs == 0 && !bus_rd && !bus_wr && !bus_ad_oe,
        "R13 reset", {busy, done, bus_ale, bus_rd, bus_wr, bus_ad_oe}, 0);
  endtask

  task automatic t_mux_write;   // R1, window change on first access (R3)
    set_cfg(0, 1, 2, 2, 1, 3, 2, 0, 0, 1);
    run_txn(0, 24'h12_3456, 16'hBEEF, 1'b1, 1'b1, "R1", 0);
  endtask

  task automatic t_mux_read_same_win;  // R3: same window, no extension
    run_txn(0, 24'h12_0042, 16'h0000, 1'b0, 1'b1, "R3", 0);
  endtask

  task automatic t_demux_new_win;  // R3: new window, extension again
    run_txn(0, 24'h34_0010, 16'h1111, 1'b0, 1'b0, "R3", 0);
  endtask

  task automatic t_zero_phases;  // R2
    set_cfg(1, 0, 0, 0, 0, 1, 0, 0, 0, 1);
    run_txn(1, 24'h34_0020, 16'hC0DE, 1'b1, 1'b0, "R2", 0);
    run_txn(1, 24'h34_0022, 16'h0000, 1'b0, 1'b1, "R2", 0);
  endtask

  task automatic t_sync_ready;  // R7
    set_cfg(2, 0, 0, 1, 1, 2, 1, 1, 0, 1);
    rdy_at = 9;  run_txn(2, 24'h34_0100, 16'h0, 1'b0, 1'b0, "R7", 0);
    rdy_at = 0;  run_txn(2, 24'h34_0102, 16'h0, 1'b0, 1'b1, "R7", 0);
  endtask

  task automatic t_async_ready;  // R8
    set_cfg(2, 0, 0, 1, 1, 2, 1, 1, 1, 1);
    rdy_at = 0;  run_txn(2, 24'h34_0104, 16'h0, 1'b0, 1'b0, "R8", 0);
    rdy_at = 8;  run_txn(2, 24'h34_0106, 16'h0, 1'b0, 1'b0, "R8", 0);
  endtask

  task automatic t_polarity;  // R9: low-active ready, sync and async
    set_cfg(3, 1, 0, 0, 0, 3, 1, 1, 0, 0);
    rdy_at = 7;  run_txn(3, 24'h34_0200, 16'h0, 1'b0, 1'b0, "R9", 0);
    set_cfg(3, 1, 0, 0, 0, 3, 1, 1, 1, 0);
    rdy_at = 2;  run_txn(3, 24'h34_0202, 16'h0, 1'b0, 1'b1, "R9", 0);
  endtask

  task automatic t_ready_off;  // R10: pin held inactive has no effect
    set_cfg(1, 1, 0, 1, 0, 32, 3, 0, 0, 1);
    rdy_at = 1000; run_txn(1, 24'h34_0300, 16'h0, 1'b0, 1'b0, "R10", 0);
  endtask

  task automatic t_busy_ignore;  // R12
    set_cfg(0, 0, 0, 1, 0, 4, 1, 0, 0, 1);
    run_txn(0, 24'h34_0400, 16'h7777, 1'b1, 1'b0, "R12", 1);
    repeat (4) begin
      chk(bus_cs == 0 && !busy, "R12 no second cycle", {bus_cs, busy}, 0);
      @(negedge clk);
    end
    chk(bus_addr == 24'h34_0400, "R12 address kept", bus_addr, 24'h34_0400);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mux_write();
    t_mux_read_same_win();
    t_demux_new_win();
    t_zero_phases();
    t_sync_ready();
    t_async_ready();
    t_polarity();
    t_ready_off();
    t_busy_ignore();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule